// File: doc/BRIEF.md
# Fully Associative Tagged Translation Buffer

This block holds up to a parameterised number of address translations, each tagged with a partition number, a context number and a real-mode flag. It is searched in parallel across every slot. A single request port with a valid/ready handshake accepts one of five operations:
- a lookup, which returns hit, slot index and translated physical address;
- an insert, which installs a translation and returns the slot it used;
- a single-page removal;
- a removal by context;
- a removal of every unlocked translation of a partition.

Page sizes are 8 KiB, 64 KiB, 512 KiB and 4 MiB, selected by a 2-bit size code: the page is 2^(13+3*code) bytes. An insert first removes every translation that would overlap the new page. It then places the new page either in a slot named by the request or in a slot chosen by the replacement rules, which use self-clearing used bits and skip locked slots.

A separate diagnostic port takes a slot number and returns, one cycle later, that slot's tag word and data word.

Top module: `tlb_assoc`

## Requirements
- R1: A slot matches a request when it is valid, its real flag and partition equal the request's, and the request address lies inside the slot's page. The context must also be equal, except when the slot is real-mode, in which case the context is not compared.
- R2: An accepted request (req_valid and req_ready both high at a clock edge) produces rsp_valid high for exactly the next cycle. req_ready is low during that cycle. For a lookup that matches, rsp_hit is 1, rsp_idx is the slot, and rsp_pa is the slot's physical page bits above the page offset joined with the request's offset bits. For a lookup that misses, rsp_hit and rsp_pa are 0.
- R3: An insert invalidates every valid slot whose page range intersects the new page, where the slot has the same real flag and partition and, for non-real pages, the same context. The stored page address is the request address with the offset bits cleared.
- R4: An insert with req_use_idx set writes the slot req_idx, whatever that slot holds.
- R5: An insert without req_use_idx takes the lowest-numbered invalid slot (counted after the overlap invalidation), and returns it in rsp_idx.
- R6: When no slot is invalid, an insert takes the lowest-numbered slot that is unlocked and has its used bit clear. When there is no such slot, it takes the last slot (N-1).
- R7: A lookup hit or an insert sets the used bit of the slot it touched. If that leaves every used bit set, all used bits except that slot's are cleared. Invalidating a slot clears its used bit.
- R8: Demap-page (op 2) invalidates the slot that a lookup with the same fields would match.
- R9: Demap-context (op 3) invalidates every slot whose partition and context equal the request's, locked or not, real or not.
- R10: Demap-all (op 4) invalidates every unlocked slot of the request's partition; locked slots survive.
- R11: rd_tag for an invalid slot is all ones. For a valid slot it is the context in bits 12:0 OR the page address (bits 55:13), the inverted size code in bits 57:56, the real flag in bit 60, and the partition in bits 63:61.
- R12: rd_data for an invalid slot is all ones. For a valid slot it is the lock bit in bit 63 and the stored physical address in the low PA_W bits.
- R13: Synchronous active-low reset leaves every slot invalid, unused and unlocked, with rsp_valid low and req_ready high.

Operation codes on req_op: 0 lookup, 1 insert, 2 demap-page, 3 demap-context, 4 demap-all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 3 | Operation code |
| req_va | input | VA_W | Virtual address |
| req_part | input | 3 | Partition number |
| req_ctx | input | 13 | Context number |
| req_real | input | 1 | Real-mode request/page |
| req_size | input | 2 | Page size code (insert) |
| req_lock | input | 1 | Lock the inserted page |
| req_pa | input | PA_W | Physical address of the inserted page |
| req_use_idx | input | 1 | Insert into req_idx |
| req_idx | input | IDX_W | Explicit slot for insert |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup matched |
| rsp_idx | output | IDX_W | Matched or written slot |
| rsp_pa | output | PA_W | Translated physical address |
| rd_idx | input | IDX_W | Diagnostic slot select |
| rd_tag | output | 64 | Tag word of selected slot, one cycle later |
| rd_data | output | 64 | Data word of selected slot, one cycle later |

## Verification
The slot state is shown only indirectly, so a wrong internal state shows up in one of three ways:
- A wrong valid or used bit surfaces as a different rsp_idx on the next insert that relies on replacement.
- A missed invalidation surfaces as a stale hit on the next lookup of the old page, or as a tag word where all ones was due.
- A stored-field error surfaces in rsp_pa or in rd_tag/rd_data one cycle after the slot is selected.

The bench therefore follows every operation with a response check and sweeps the whole diagnostic port at intervals. This bounds the latency of detection to the next sweep.

// File: rtl/tlb_pkg.sv
// Package: shared operation codes, tag field constants and the page-size
// mask function for the associative translation buffer.
package tlb_pkg;

    typedef enum logic [2:0] {
        OP_LOOKUP    = 3'd0,
        OP_INSERT    = 3'd1,
        OP_DEMAP_PG  = 3'd2,
        OP_DEMAP_CTX = 3'd3,
        OP_DEMAP_ALL = 3'd4
    } tlb_op_e;

    localparam int PART_W     = 3;
    localparam int CTX_W      = 13;
    localparam int SZ_W       = 2;
    localparam int BASE_SHIFT = 13;
    localparam int SZ_STEP    = 3;

    // Offset mask of a page of the given size code.
    function automatic logic [63:0] size_mask(input logic [SZ_W-1:0] code);
        return (64'd1 << (BASE_SHIFT + SZ_STEP * int'(code))) - 64'd1;
    endfunction

endpackage

// File: rtl/tlb_slot_cmp.sv
// Module: per-slot comparator. Produces the lookup/demap-page match, the
// insert overlap test and the partition/context equality flags for one slot.
// Assumes the stored page address has its offset bits cleared.
module tlb_slot_cmp
    import tlb_pkg::*;
#(
    parameter int VA_W = 48
) (
    input  logic              s_valid,
    input  logic              s_real,
    input  logic [PART_W-1:0] s_part,
    input  logic [CTX_W-1:0]  s_ctx,
    input  logic [VA_W-1:0]   s_va,
    input  logic [SZ_W-1:0]   s_sz,
    input  logic              q_real,
    input  logic [PART_W-1:0] q_part,
    input  logic [CTX_W-1:0]  q_ctx,
    input  logic [VA_W-1:0]   q_va,
    input  logic [SZ_W-1:0]   q_sz,
    output logic              m_hit,
    output logic              m_ovl,
    output logic              m_ctx,
    output logic              m_part
);
    logic [VA_W-1:0] s_mask, q_mask, big_mask;
    logic            tag_eq;

    // Equality of the tag fields and both match tests.
    always_comb begin
        s_mask   = VA_W'(size_mask(s_sz));
        q_mask   = VA_W'(size_mask(q_sz));
        big_mask = s_mask | q_mask;
        m_part   = s_part == q_part;
        m_ctx    = m_part && (s_ctx == q_ctx);
        tag_eq   = s_valid && (s_real == q_real) && m_part &&
                   (s_real || (s_ctx == q_ctx));
        m_hit    = tag_eq && ((q_va & ~s_mask) == s_va);
        m_ovl    = tag_eq && ((q_va & ~big_mask) == (s_va & ~big_mask));
    end
endmodule

// File: rtl/tlb_first_set.sv
// Module: priority encoder returning the lowest set bit of a vector.
// Assumes N >= 2.
module tlb_first_set #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_assoc.sv
// Module: fully associative tagged translation buffer with lookup, insert,
// demap-page, demap-context and demap-all, plus a registered diagnostic
// read port. One operation is accepted at a time; its response appears on
// the next cycle. Assumes N >= 2, VA_W <= 56 and PA_W <= 63.
module tlb_assoc
    import tlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int VA_W  = 48,
    parameter int PA_W  = 40,
    localparam int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [VA_W-1:0]   req_va,
    input  logic [PART_W-1:0] req_part,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic              req_real,
    input  logic [SZ_W-1:0]   req_size,
    input  logic              req_lock,
    input  logic [PA_W-1:0]   req_pa,
    input  logic              req_use_idx,
    input  logic [IDX_W-1:0]  req_idx,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [PA_W-1:0]   rsp_pa,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [63:0]       rd_tag,
    output logic [63:0]       rd_data
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [N-1:0]      valid_q, used_q, lock_q;
    logic [VA_W-1:0]   e_va   [N];
    logic [SZ_W-1:0]   e_sz   [N];
    logic [PART_W-1:0] e_part [N];
    logic [CTX_W-1:0]  e_ctx  [N];
    logic              e_real [N];
    logic [PA_W-1:0]   e_pa   [N];

    logic [N-1:0] hit_vec, ovl_vec, ctx_vec, part_vec, kill, valid_after;
    logic [N-1:0] used_next, touch_oh;
    logic         accept, do_lookup, do_ins, hit_found, free_found, cand_found;
    logic [IDX_W-1:0] hit_idx, free_idx, cand_idx, victim, touch_idx;
    logic         touch_en;
    logic [VA_W-1:0] q_mask;
    logic [PA_W-1:0] pa_mask, pa_calc;

    assign req_ready = !rsp_valid;
    assign accept    = req_valid && req_ready;
    assign do_lookup = accept && (req_op == OP_LOOKUP);
    assign do_ins    = accept && (req_op == OP_INSERT);
    assign q_mask    = VA_W'(size_mask(req_size));

    // One comparator per slot.
    for (genvar g = 0; g < N; g++) begin : g_slot
        tlb_slot_cmp #(.VA_W(VA_W)) u_cmp (
            .s_valid(valid_q[g]), .s_real(e_real[g]), .s_part(e_part[g]),
            .s_ctx(e_ctx[g]), .s_va(e_va[g]), .s_sz(e_sz[g]),
            .q_real(req_real), .q_part(req_part), .q_ctx(req_ctx),
            .q_va(req_va), .q_sz(req_size),
            .m_hit(hit_vec[g]), .m_ovl(ovl_vec[g]),
            .m_ctx(ctx_vec[g]), .m_part(part_vec[g])
        );
    end

    // Select the slots an accepted operation invalidates.
    always_comb begin
        kill = '0;
        if (accept) begin
            case (req_op)
                OP_INSERT:    kill = ovl_vec;
                OP_DEMAP_PG:  kill = hit_vec;
                OP_DEMAP_CTX: kill = valid_q & ctx_vec;
                OP_DEMAP_ALL: kill = valid_q & part_vec & ~lock_q;
                default:      kill = '0;
            endcase
        end
        valid_after = valid_q & ~kill;
    end

    tlb_first_set #(.N(N), .IDX_W(IDX_W)) u_pick_hit (
        .vec(hit_vec), .found(hit_found), .idx(hit_idx));
    tlb_first_set #(.N(N), .IDX_W(IDX_W)) u_pick_free (
        .vec(~valid_after), .found(free_found), .idx(free_idx));
    tlb_first_set #(.N(N), .IDX_W(IDX_W)) u_pick_cand (
        .vec(~lock_q & ~used_q), .found(cand_found), .idx(cand_idx));

    // Victim choice: explicit slot, free slot, unused unlocked slot, last slot.
    always_comb begin
        if (req_use_idx)     victim = req_idx;
        else if (free_found) victim = free_idx;
        else if (cand_found) victim = cand_idx;
        else                 victim = LAST;
    end

    // Used-bit update with global clear when all become set.
    always_comb begin
        touch_en  = do_ins || (do_lookup && hit_found);
        touch_idx = do_ins ? victim : hit_idx;
        touch_oh  = N'(1) << touch_idx;
        used_next = used_q & ~kill;
        if (touch_en) begin
            used_next = used_next | touch_oh;
            if (&used_next) used_next = touch_oh;
        end
    end

    // Physical address of a lookup hit: page bits plus request offset.
    always_comb begin
        pa_mask = PA_W'(size_mask(e_sz[hit_idx]));
        pa_calc = (e_pa[hit_idx] & ~pa_mask) | (PA_W'(req_va) & pa_mask);
    end

    // Slot state flags, reset to empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            used_q  <= '0;
            lock_q  <= '0;
        end else begin
            valid_q <= valid_after | (do_ins ? touch_oh : '0);
            used_q  <= used_next;
            lock_q  <= (lock_q & ~kill);
            if (do_ins) lock_q[victim] <= req_lock;
        end
    end

    // Slot payload fields, written on insert.
    always_ff @(posedge clk) begin
        if (do_ins) begin
            e_va[victim]   <= req_va & ~q_mask;
            e_sz[victim]   <= req_size;
            e_part[victim] <= req_part;
            e_ctx[victim]  <= req_ctx;
            e_real[victim] <= req_real;
            e_pa[victim]   <= req_pa;
        end
    end

    // Response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_idx   <= '0;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_hit   <= do_lookup && hit_found;
            rsp_idx   <= do_ins ? victim : (do_lookup ? hit_idx : '0);
            rsp_pa    <= (do_lookup && hit_found) ? pa_calc : '0;
        end
    end

    // Diagnostic tag and data words of the selected slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_tag  <= '1;
            rd_data <= '1;
        end else if (!valid_q[rd_idx]) begin
            rd_tag  <= '1;
            rd_data <= '1;
        end else begin
            rd_tag  <= 64'(e_ctx[rd_idx]) | 64'(e_va[rd_idx]) |
                       (64'(~e_sz[rd_idx]) << 56) |
                       (64'(e_real[rd_idx]) << 60) |
                       (64'(e_part[rd_idx]) << 61);
            rd_data <= 64'(e_pa[rd_idx]) | (64'(lock_q[rd_idx]) << 63);
        end
    end

    // Assertions guarding the control state.
    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid); // R2
    AST_NO_ACCEPT_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R2
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R1
    AST_INSERT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        do_ins |=> valid_q[rsp_idx]); // R5
    AST_USED_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (used_q & ~valid_q) == '0); // R7
    AST_USED_NEVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(used_q) < N); // R7
    AST_LOCKED_SURVIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == OP_DEMAP_ALL) |=>
        (valid_q & lock_q) == $past(valid_q & lock_q)); // R10
endmodule

// File: tb/tb_tlb_assoc.sv
`timescale 1ns/1ps
module tb_tlb_assoc;
    localparam int N = 16;
    localparam int IW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_real = 0, req_lock = 0, req_use_idx = 0;
    logic [2:0] req_op = 0, req_part = 0;
    logic [47:0] req_va = 0;
    logic [12:0] req_ctx = 0;
    logic [1:0] req_size = 0;
    logic [39:0] req_pa = 0;
    logic [IW-1:0] req_idx = 0, rd_idx = 0;
    logic req_ready, rsp_valid, rsp_hit;
    logic [IW-1:0] rsp_idx;
    logic [39:0] rsp_pa;
    logic [63:0] rd_tag, rd_data;

    int checks = 0, fails = 0;
    bit done = 0;

    // model state
    bit m_valid[N], m_used[N], m_lock[N], m_real[N];
    logic [47:0] m_va[N];
    logic [1:0] m_sz[N];
    logic [2:0] m_part[N];
    logic [12:0] m_ctx[N];
    logic [39:0] m_pa[N];

    always #10 clk = ~clk;

    tlb_assoc #(.N(N), .VA_W(48), .PA_W(40)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_va(req_va), .req_part(req_part), .req_ctx(req_ctx),
        .req_real(req_real), .req_size(req_size), .req_lock(req_lock),
        .req_pa(req_pa), .req_use_idx(req_use_idx), .req_idx(req_idx),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
        .rsp_pa(rsp_pa), .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_data(rd_data));

    function automatic logic [63:0] mmask(input logic [1:0] c);
        return (64'd1 << (13 + 3 * int'(c))) - 64'd1;
    endfunction

    function automatic bit slot_match(input int k, input logic [47:0] va,
            input logic [2:0] p, input logic [12:0] c, input bit rl);
        return m_valid[k] && m_real[k] == rl && m_part[k] == p &&
               (m_real[k] || m_ctx[k] == c) &&
               ((va & ~48'(mmask(m_sz[k]))) == m_va[k]);
    endfunction

    function automatic logic [63:0] exp_tag(input int k);
        if (!m_valid[k]) return '1;
        return 64'(m_ctx[k]) | 64'(m_va[k]) | (64'(~m_sz[k]) << 56) |
               (64'(m_real[k]) << 60) | (64'(m_part[k]) << 61);
    endfunction

    function automatic logic [63:0] exp_data(input int k);
        if (!m_valid[k]) return '1;
        return 64'(m_pa[k]) | (64'(m_lock[k]) << 63);
    endfunction

    task automatic check(input bit ok, input string rq, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic touch(input int k);
        bit all;
        m_used[k] = 1;
        all = 1;
        for (int i = 0; i < N; i++) if (!m_used[i]) all = 0;
        if (all) begin
            for (int i = 0; i < N; i++) m_used[i] = 0;
            m_used[k] = 1;
        end
    endtask

    task automatic kill_slot(input int k);
        m_valid[k] = 0;
        m_used[k] = 0;
        m_lock[k] = 0;
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_used[i] = 0; m_lock[i] = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        req_valid = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        model_reset();
        @(negedge clk);
        check(req_ready === 1'b1 && rsp_valid === 1'b0, "R13 ready/rsp after reset",
              {req_ready, rsp_valid}, 2'b10);
    endtask

    task automatic do_op(input logic [2:0] op, input logic [47:0] va,
            input logic [2:0] p, input logic [12:0] c, input bit rl,
            input logic [1:0] sz, input bit lk, input logic [39:0] pa,
            input bit ui, input logic [IW-1:0] ix, input string rq);
        bit e_hit;
        int e_idx, hk;
        logic [39:0] e_pa;
        logic [63:0] big;
        e_hit = 0; e_idx = 0; e_pa = 0; hk = -1;
        // model
        case (op)
            3'd0: begin
                for (int i = N - 1; i >= 0; i--) if (slot_match(i, va, p, c, rl)) hk = i;
                if (hk >= 0) begin
                    e_hit = 1; e_idx = hk;
                    e_pa = (m_pa[hk] & ~40'(mmask(m_sz[hk]))) |
                           (40'(va) & 40'(mmask(m_sz[hk])));
                    touch(hk);
                end
            end
            3'd1: begin
                for (int i = 0; i < N; i++) begin
                    big = mmask(m_sz[i]) | mmask(sz);
                    if (m_valid[i] && m_real[i] == rl && m_part[i] == p &&
                        (rl || m_ctx[i] == c) &&
                        ((va & ~48'(big)) == (m_va[i] & ~48'(big)))) kill_slot(i);
                end
                if (ui) e_idx = ix;
                else begin
                    e_idx = -1;
                    for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) e_idx = i;
                    if (e_idx < 0)
                        for (int i = N - 1; i >= 0; i--)
                            if (!m_lock[i] && !m_used[i]) e_idx = i;
                    if (e_idx < 0) e_idx = N - 1;
                end
                m_valid[e_idx] = 1; m_lock[e_idx] = lk; m_real[e_idx] = rl;
                m_va[e_idx] = va & ~48'(mmask(sz)); m_sz[e_idx] = sz;
                m_part[e_idx] = p; m_ctx[e_idx] = c; m_pa[e_idx] = pa;
                touch(e_idx);
            end
            3'd2: for (int i = 0; i < N; i++) if (slot_match(i, va, p, c, rl)) kill_slot(i);
            3'd3: for (int i = 0; i < N; i++)
                      if (m_valid[i] && m_part[i] == p && m_ctx[i] == c) kill_slot(i);
            default: for (int i = 0; i < N; i++)
                      if (m_valid[i] && !m_lock[i] && m_part[i] == p) kill_slot(i);
        endcase
        // drive
        @(negedge clk);
        check(req_ready === 1'b1, {rq, " R2 ready before request"}, req_ready, 1);
        req_valid = 1; req_op = op; req_va = va; req_part = p; req_ctx = c;
        req_real = rl; req_size = sz; req_lock = lk; req_pa = pa;
        req_use_idx = ui; req_idx = ix;
        @(negedge clk);
        req_valid = 0;
        check(rsp_valid === 1'b1 && req_ready === 1'b0, {rq, " R2 response cycle"},
              {rsp_valid, req_ready}, 2'b10);
        if (op == 3'd0) begin
            check(rsp_hit === e_hit, {rq, " R1 hit"}, rsp_hit, e_hit);
            check(rsp_pa === e_pa, {rq, " R2 pa"}, rsp_pa, e_pa);
            if (e_hit) check(rsp_idx === IW'(e_idx), {rq, " R2 idx"}, rsp_idx, e_idx);
        end else if (op == 3'd1) begin
            check(rsp_idx === IW'(e_idx), {rq, " R5/R6 victim"}, rsp_idx, e_idx);
        end else begin
            check(rsp_hit === 1'b0, {rq, " R8 no hit on demap"}, rsp_hit, 0);
        end
    endtask

    task automatic scan(input string rq);
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            rd_idx = IW'(k);
            @(negedge clk);
            check(rd_tag === exp_tag(k), {rq, " R11 tag"}, rd_tag, exp_tag(k));
            check(rd_data === exp_data(k), {rq, " R12 data"}, rd_data, exp_data(k));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [47:0] va;
        int k;
        void'($urandom(32'd7));
        do_reset();
        scan("R13 reset contents");
        // R5 R2 R1: basic insert/lookup, context rules
        do_op(1, 48'h10000, 1, 5, 0, 0, 0, 40'hABCDE000, 0, 0, "R5 first insert");
        do_op(0, 48'h10123, 1, 5, 0, 0, 0, 0, 0, 0, "R2 lookup hit");
        do_op(0, 48'h10123, 1, 6, 0, 0, 0, 0, 0, 0, "R1 ctx mismatch");
        do_op(0, 48'h10123, 2, 5, 0, 0, 0, 0, 0, 0, "R1 part mismatch");
        do_op(1, 48'h20000, 1, 3, 1, 1, 0, 40'h55550000, 0, 0, "R5 real insert");
        do_op(0, 48'h2F00F, 1, 7, 1, 0, 0, 0, 0, 0, "R1 real ignores ctx");
        do_op(0, 48'h2F00F, 1, 3, 0, 0, 0, 0, 0, 0, "R1 real flag mismatch");
        // R3 overlap
        do_op(1, 48'h40000, 1, 5, 0, 0, 0, 40'h1000, 0, 0, "R3 small page");
        do_op(1, 48'h00000, 1, 5, 0, 2, 0, 40'h800000, 0, 0, "R3 big overlapping page");
        do_op(0, 48'h40010, 1, 5, 0, 0, 0, 0, 0, 0, "R3 old page now hits big");
        scan("R3 after overlap");
        // R4 explicit slot
        do_op(1, 48'h900000, 0, 1, 0, 3, 0, 40'hC00000, 1, 9, "R4 explicit slot");
        do_op(0, 48'h9ABCDE, 0, 1, 0, 0, 0, 0, 0, 0, "R4 lookup 4M page");
        // R8 R9
        do_op(2, 48'h900000, 0, 1, 0, 0, 0, 0, 0, 0, "R8 demap page");
        do_op(0, 48'h900000, 0, 1, 0, 0, 0, 0, 0, 0, "R8 lookup after demap");
        do_op(3, 0, 1, 3, 0, 0, 0, 0, 0, 0, "R9 demap ctx");
        scan("R9 after demap ctx");
        // R7 R6: fill, global used clear, all-locked fallback
        do_reset();
        for (int i = 0; i < N; i++)
            do_op(1, 48'(i) << 16, 0, 0, 0, 0, 0, 40'(i) << 13, 0, 0, "R7 fill");
        do_op(1, 48'h300000, 0, 0, 0, 0, 0, 40'h1, 0, 0, "R6 unused victim");
        do_op(0, 48'h20000, 0, 0, 0, 0, 0, 0, 0, 0, "R7 lookup touch");
        do_op(1, 48'h310000, 0, 0, 0, 0, 0, 40'h2, 0, 0, "R6 next unused victim");
        do_reset();
        for (int i = 0; i < N; i++)
            do_op(1, 48'(i) << 16, 2, 4, 0, 0, 1, 40'(i) << 13, 0, 0, "R6 fill locked");
        do_op(1, 48'h500000, 2, 4, 0, 0, 0, 40'h3, 0, 0, "R6 all locked last");
        do_op(4, 0, 2, 0, 0, 0, 0, 0, 0, 0, "R10 demap all");
        scan("R10 locked survive");
        do_op(3, 0, 2, 4, 0, 0, 0, 0, 0, 0, "R9 demap ctx locked");
        scan("R9 locked removed");
        // random mix
        do_reset();
        for (int n = 0; n < 600; n++) begin
            int r;
            bit rl;
            logic [2:0] p;
            logic [12:0] c;
            r = int'($urandom % 100);
            va = 48'($urandom & 32'hFFFFFF);
            p = 3'($urandom % 2); c = 13'($urandom % 3); rl = ($urandom % 5) == 0;
            k = int'($urandom % N);
            if (($urandom % 2) == 1 && m_valid[k]) begin
                va = m_va[k] | (va & 48'(mmask(m_sz[k])));
                p = m_part[k]; rl = m_real[k];
                if (!rl) c = m_ctx[k];
            end
            if (r < 40) do_op(0, va, p, c, rl, 0, 0, 0, 0, 0, "R1 rand lookup");
            else if (r < 78) do_op(1, va, p, c, rl, 2'($urandom), ($urandom % 6) == 0,
                                   40'($urandom), ($urandom % 8) == 0, IW'($urandom),
                                   "R3 rand insert");
            else if (r < 88) do_op(2, va, p, c, rl, 0, 0, 0, 0, 0, "R8 rand demap");
            else if (r < 95) do_op(3, 0, p, c, 0, 0, 0, 0, 0, 0, "R9 rand demap ctx");
            else do_op(4, 0, p, 0, 0, 0, 0, 0, 0, 0, "R10 rand demap all");
            if (n % 100 == 99) scan("R11 rand scan");
        end
        finish_run();
    end
endmodule